// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a per-core interrupt timer. A down-counter is loaded from an initial-count register and decremented once per divided tick. The divided tick comes from a prescaler that runs on a bus-clock enable and is set by a power-of-two divide code. A timer table entry sets the interrupt vector, a mask bit and the choice between one-shot and periodic operation. A one-shot count stops at zero; a periodic count reloads and keeps running.

Each expiry produces a one-cycle pulse that carries the vector and adds one to a saturating pending counter. While the entry is unmasked and expiries are pending, the block offers an injection request. Every accepted request (request and acknowledge high in the same cycle) consumes one pending expiry. A software-enable control sits beside the timer. Turning it off masks the entry and drops all pending expiries, and while it is off every entry write is stored masked. Bus decoding and interrupt priority arbitration belong to the surrounding logic.

Top module: `local_irq_timer`

## Requirements
- R1: The divide code `div_data` selects a divisor of 2 to the power ((({div_data[3], div_data[1:0]}) + 1) mod 8). Code bit 2 is ignored, code 4'b1011 gives divide by 1 and code 4'b0000 gives divide by 2. With `bus_tick` held high, a count of N expires N times the divisor cycles after it is loaded.
- R2: A divide-code write restarts the prescaler from zero and leaves the current count unchanged.
- R3: An initial-count write stops any countdown in progress and restarts it from the written value. The next cycle shows that value on `cur_count`, and the pending counter reads zero.
- R4: A written initial count of zero leaves the timer stopped. `cur_count` reads zero and no expiry occurs.
- R5: In one-shot mode (entry bit 17 clear) the count reads zero after expiry and stays at zero, with no further expiry, until the initial count is written again.
- R6: In periodic mode (entry bit 17 set) the count reloads the initial count at expiry and keeps running, so expiries repeat every initial-count times divisor cycles.
- R7: Each expiry raises `expire_pulse` for one cycle, with `expire_vector` set to entry bits [7:0]. It also increments `pend_count`, which saturates at 2^PEND_W-1 instead of wrapping.
- R8: `inject_req` is high exactly when the entry mask (bit 16) is clear and `pend_count` is nonzero, and `inject_vector` carries entry bits [7:0]. An accepted request decrements `pend_count`. An acknowledge while the request is low changes nothing. An expiry and an acceptance in the same cycle leave the count unchanged.
- R9: A control write with `ctl_enable` low sets the entry mask bit and clears `pend_count`.
- R10: An entry write keeps only bits [7:0] (vector), 12 (delivery status), 16 (mask) and 17 (periodic) and reads the others as zero. While software is disabled, the mask bit is stored as one whatever was written.
- R11: After reset the count is zero and stopped, the entry reads 32'h0001_0000, software is disabled, the divide code is zero, and `pend_count`, `inject_req` and `expire_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_tick | input | 1 | Bus-clock enable that feeds the prescaler |
| init_wr | input | 1 | Initial-count write strobe |
| init_data | input | CNT_W | Initial count value |
| div_wr | input | 1 | Divide-code write strobe |
| div_data | input | 4 | Divide code |
| entry_wr | input | 1 | Timer entry write strobe |
| entry_data | input | 32 | Timer entry write value |
| ctl_wr | input | 1 | Software-enable control write strobe |
| ctl_enable | input | 1 | Software-enable value written |
| cur_count | output | CNT_W | Current count |
| entry_value | output | 32 | Stored timer entry |
| expire_pulse | output | 1 | One-cycle expiry pulse |
| expire_vector | output | 8 | Vector carried with the expiry pulse |
| pend_count | output | PEND_W | Pending expiry count |
| inject_req | output | 1 | Injection offered |
| inject_vector | output | 8 | Vector to inject |
| inject_ack | input | 1 | Injection accepted by the consumer |

## Verification
The bench sweeps all sixteen divide codes and measures the cycles to expiry. A design that read the wrong code bits, or that did not wrap the exponent, would give divide by 256 or a wrong divisor for some code. It rewrites the divide code in the middle of a prescaler cycle; a prescaler that is not restarted would expire early. It also rewrites the count partway down; a design that kept counting the old value would expire too soon. Other tests check that a one-shot count stays at zero and that a periodic count reloads with the same period. They also push the pending counter past its limit, where a wrapping counter would read zero, and fire an expiry in the same cycle as an acceptance, where a design that gave one of the two priority would be off by one. The entry masking is checked after software disable and on writes made while disabled, and an acknowledge while masked must consume nothing.

// File: rtl/lit_pkg.sv
package lit_pkg;

    localparam int VEC_W      = 8;
    localparam int ENTRY_W    = 32;
    localparam int STATUS_BIT = 12;
    localparam int MASK_BIT   = 16;
    localparam int PERIOD_BIT = 17;
    localparam int SHIFT_W    = 3;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic             status;
        logic [VEC_W-1:0] vector;
    } entry_t;

    typedef enum logic [1:0] {
        CNT_IDLE = 2'd0,
        CNT_RUN  = 2'd1,
        CNT_DONE = 2'd2
    } cnt_state_e;

    function automatic entry_t entry_unpack(input logic [ENTRY_W-1:0] raw);
        entry_t e;
        e.periodic = raw[PERIOD_BIT];
        e.masked   = raw[MASK_BIT];
        e.status   = raw[STATUS_BIT];
        e.vector   = raw[VEC_W-1:0];
        return e;
    endfunction

    function automatic logic [ENTRY_W-1:0] entry_pack(input entry_t e);
        logic [ENTRY_W-1:0] raw;
        raw             = '0;
        raw[PERIOD_BIT] = e.periodic;
        raw[MASK_BIT]   = e.masked;
        raw[STATUS_BIT] = e.status;
        raw[VEC_W-1:0]  = e.vector;
        return raw;
    endfunction

    // Exponent of the divisor: code bits {3,1,0} plus one, wrapping in 3 bits.
    function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] code);
        logic [SHIFT_W-1:0] sel;
        sel = {code[3], code[1:0]};
        return sel + SHIFT_W'(1);
    endfunction

endpackage

// File: rtl/lit_prescaler.sv
module lit_prescaler
    import lit_pkg::*;
#(
    parameter int MAX_SHIFT = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_tick,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int PRE_W = MAX_SHIFT;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = {PRE_W{1'b1}} >> (PRE_W - int'(shift));
        tick  = bus_tick && (pre_q == limit);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
        end else if (bus_tick) begin
            pre_q <= tick ? '0 : pre_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/lit_countdown.sv
module lit_countdown
    import lit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    output logic [CNT_W-1:0] count,
    output logic             fire
);
    cnt_state_e       state_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] reload_q;

    assign count = count_q;

    always_comb begin
        fire = tick && (state_q == CNT_RUN) && (count_q == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= CNT_IDLE;
            count_q  <= '0;
            reload_q <= '0;
        end else if (load) begin
            reload_q <= load_val;
            count_q  <= load_val;
            state_q  <= (load_val == '0) ? CNT_IDLE : CNT_RUN;
        end else if (fire) begin
            if (periodic) begin
                count_q <= reload_q;
            end else begin
                count_q <= '0;
                state_q <= CNT_DONE;
            end
        end else if (tick && state_q == CNT_RUN) begin
            count_q <= count_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/lit_pending.sv
module lit_pending #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              inc,
    input  logic              dec,
    output logic [PEND_W-1:0] count
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    logic [PEND_W-1:0] cnt_q;

    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (cnt_q != PEND_MAX) cnt_q <= cnt_q + PEND_W'(1);
                2'b01:   if (cnt_q != '0)       cnt_q <= cnt_q - PEND_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/local_irq_timer.sv
module local_irq_timer
    import lit_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_tick,
    input  logic               init_wr,
    input  logic [CNT_W-1:0]   init_data,
    input  logic               div_wr,
    input  logic [3:0]         div_data,
    input  logic               entry_wr,
    input  logic [ENTRY_W-1:0] entry_data,
    input  logic               ctl_wr,
    input  logic               ctl_enable,
    output logic [CNT_W-1:0]   cur_count,
    output logic [ENTRY_W-1:0] entry_value,
    output logic               expire_pulse,
    output logic [VEC_W-1:0]   expire_vector,
    output logic [PEND_W-1:0]  pend_count,
    output logic               inject_req,
    output logic [VEC_W-1:0]   inject_vector,
    input  logic               inject_ack
);
    localparam logic [ENTRY_W-1:0] ENTRY_RST = ENTRY_W'(1) << MASK_BIT;

    logic             sw_en_q;
    logic [3:0]       div_code_q;
    entry_t           entry_q;
    entry_t           entry_d;
    logic             sw_disable;
    logic             tick;
    logic             fire;
    logic             consume;
    logic             pulse_q;
    logic [VEC_W-1:0] pulse_vec_q;

    assign sw_disable = ctl_wr && !ctl_enable;

    // Entry update: written value, forced mask while disabled or on disable.
    always_comb begin
        entry_d = entry_wr ? entry_unpack(entry_data) : entry_q;
        if (entry_wr && !sw_en_q) entry_d.masked = 1'b1;
        if (sw_disable)           entry_d.masked = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_en_q     <= 1'b0;
            div_code_q  <= '0;
            entry_q     <= entry_unpack(ENTRY_RST);
            pulse_q     <= 1'b0;
            pulse_vec_q <= '0;
        end else begin
            if (ctl_wr) sw_en_q    <= ctl_enable;
            if (div_wr) div_code_q <= div_data;
            entry_q     <= entry_d;
            pulse_q     <= fire;
            pulse_vec_q <= entry_q.vector;
        end
    end

    lit_prescaler #(.MAX_SHIFT(7)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .bus_tick (bus_tick),
        .restart  (div_wr || init_wr),
        .shift    (div_shift(div_wr ? div_data : div_code_q)),
        .tick     (tick)
    );

    lit_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (init_wr),
        .load_val (init_data),
        .tick     (tick),
        .periodic (entry_q.periodic),
        .count    (cur_count),
        .fire     (fire)
    );

    assign consume = inject_req && inject_ack;

    lit_pending #(.PEND_W(PEND_W)) u_pend (
        .clk   (clk),
        .rst   (rst),
        .clear (init_wr || sw_disable),
        .inc   (fire),
        .dec   (consume),
        .count (pend_count)
    );

    assign inject_req    = !entry_q.masked && (pend_count != '0);
    assign inject_vector = entry_q.vector;
    assign entry_value   = entry_pack(entry_q);
    assign expire_pulse  = pulse_q;
    assign expire_vector = pulse_vec_q;
endmodule

// File: rtl/local_irq_timer_chk.sv
module local_irq_timer_chk #(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              init_wr,
    input logic [CNT_W-1:0]  init_data,
    input logic              entry_wr,
    input logic              ctl_wr,
    input logic              ctl_enable,
    input logic              sw_en,
    input logic [CNT_W-1:0]  cur_count,
    input logic [31:0]       entry_value,
    input logic              expire_pulse,
    input logic [PEND_W-1:0] pend_count,
    input logic              inject_req,
    input logic              inject_ack
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
        $past(init_wr) |-> (cur_count == $past(init_data)) && (pend_count == '0));

    assert_oneshot_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (expire_pulse && !$past(entry_value[17])) |-> (cur_count == '0));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(pend_count) == PEND_MAX && !$past(inject_req && inject_ack)
         && !$past(init_wr) && !$past(ctl_wr && !ctl_enable))
        |-> (pend_count == PEND_MAX));

    assert_req_needs_pending_R8: assert property (@(posedge clk) disable iff (rst)
        inject_req |-> (pend_count != '0) && !entry_value[16]);

    assert_disable_masks_R9: assert property (@(posedge clk) disable iff (rst)
        $past(ctl_wr && !ctl_enable) |-> entry_value[16] && (pend_count == '0));

    assert_forced_mask_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(entry_wr) && !$past(sw_en)) |-> entry_value[16]);
endmodule

bind local_irq_timer local_irq_timer_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .init_wr      (init_wr),
    .init_data    (init_data),
    .entry_wr     (entry_wr),
    .ctl_wr       (ctl_wr),
    .ctl_enable   (ctl_enable),
    .sw_en        (sw_en_q),
    .cur_count    (cur_count),
    .entry_value  (entry_value),
    .expire_pulse (expire_pulse),
    .pend_count   (pend_count),
    .inject_req   (inject_req),
    .inject_ack   (inject_ack)
);

// File: tb/test_local_irq_timer.sv
module test_local_irq_timer;
    localparam int CNT_W  = 32;
    localparam int PEND_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_tick = 1'b0;
    logic              init_wr = 1'b0;
    logic [CNT_W-1:0]  init_data = '0;
    logic              div_wr = 1'b0;
    logic [3:0]        div_data = '0;
    logic              entry_wr = 1'b0;
    logic [31:0]       entry_data = '0;
    logic              ctl_wr = 1'b0;
    logic              ctl_enable = 1'b0;
    logic [CNT_W-1:0]  cur_count;
    logic [31:0]       entry_value;
    logic              expire_pulse;
    logic [7:0]        expire_vector;
    logic [PEND_W-1:0] pend_count;
    logic              inject_req;
    logic [7:0]        inject_vector;
    logic              inject_ack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    local_irq_timer #(.CNT_W(CNT_W), .PEND_W(PEND_W)) i_local_irq_timer (.*);

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_init(input logic [CNT_W-1:0] v);
        init_wr = 1'b1; init_data = v;
        @(negedge clk);
        init_wr = 1'b0;
    endtask

    task automatic put_div(input logic [3:0] v);
        div_wr = 1'b1; div_data = v;
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic put_entry(input logic [31:0] v);
        entry_wr = 1'b1; entry_data = v;
        @(negedge clk);
        entry_wr = 1'b0;
    endtask

    task automatic put_ctl(input logic en);
        ctl_wr = 1'b1; ctl_enable = en;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    // Cycles from the write edge until expire_pulse is seen.
    task automatic measure(output int n);
        n = 0;
        while (n < 3000) begin
            @(negedge clk);
            n++;
            if (expire_pulse) break;
        end
    endtask

    function automatic int exp_div(input logic [3:0] c);
        return 1 << ((int'({c[3], c[1:0]}) + 1) % 8);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n;
        int seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 count", cur_count, 0);
        chk("R11 entry", entry_value, 32'h0001_0000);
        chk("R11 pending", pend_count, 0);
        chk("R11 req", inject_req, 0);
        chk("R11 pulse", expire_pulse, 0);

        // R1 divide code sweep, one-shot count of 3
        bus_tick = 1'b1;
        for (int c = 0; c < 16; c++) begin
            put_div(4'(c));
            put_init(3);
            measure(n);
            chk($sformatf("R1 code %0d cycles", c), n, 3 * exp_div(4'(c)));
            // R5 one-shot reads zero after expiry
            chk("R5 zero after expiry", cur_count, 0);
        end

        // R5 stays at zero with no further expiry
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (expire_pulse) seen++;
        end
        chk("R5 no re-expiry", seen, 0);
        chk("R5 still zero", cur_count, 0);

        // R4 zero initial count stays stopped
        put_div(4'b1011);
        put_init(0);
        chk("R4 reads zero", cur_count, 0);
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (expire_pulse) seen++;
        end
        chk("R4 no expiry", seen, 0);

        // R3 rewrite partway restarts from the new value
        put_init(10);
        chk("R3 loaded", cur_count, 10);
        repeat (4) @(negedge clk);
        chk("R3 counting", cur_count, 6);
        put_init(5);
        chk("R3 reloaded", cur_count, 5);
        measure(n);
        chk("R3 restart cycles", n, 5);

        // R2 divide write restarts prescaler, count kept
        put_div(4'b0001);               // divide by 4
        put_init(2);
        repeat (2) @(negedge clk);      // prescaler partway
        bus_tick = 1'b0;
        chk("R2 count before", cur_count, 2);
        put_div(4'b0001);
        chk("R2 count kept", cur_count, 2);
        bus_tick = 1'b1;
        div_wr = 1'b0;
        measure(n);
        chk("R2 full period after restart", n, 8);

        // R6 periodic mode
        put_entry(32'h0002_0033);
        chk("R10 forced mask while disabled", entry_value, 32'h0003_0033);
        put_div(4'b1011);
        put_init(5);
        measure(n);
        chk("R6 first period", n, 5);
        chk("R6 reload value", cur_count, 5);
        chk("R7 pulse vector", expire_vector, 8'h33);
        measure(n);
        chk("R6 second period", n, 5);
        put_div(4'b0000);
        put_init(3);
        measure(n);
        chk("R6 period div2", n, 6);
        measure(n);
        chk("R6 repeat div2", n, 6);

        // R8 pending and inject
        bus_tick = 1'b0;
        put_ctl(1'b1);
        put_entry(32'h0002_0042);
        chk("R10 enabled write", entry_value, 32'h0002_0042);
        put_div(4'b1011);
        put_init(1);
        chk("R3 pending cleared", pend_count, 0);
        chk("R8 no req at zero", inject_req, 0);
        bus_tick = 1'b1;
        @(negedge clk);
        chk("R7 pulse high", expire_pulse, 1);
        chk("R7 pulse vector 42", expire_vector, 8'h42);
        repeat (2) @(negedge clk);
        bus_tick = 1'b0;
        @(negedge clk);
        chk("R7 pending three", pend_count, 3);
        chk("R7 pulse is one cycle", expire_pulse, 0);
        chk("R8 req", inject_req, 1);
        chk("R8 vector", inject_vector, 8'h42);
        inject_ack = 1'b1;
        @(negedge clk);
        inject_ack = 1'b0;
        chk("R8 consumed", pend_count, 2);
        put_entry(32'h0003_0042);
        chk("R8 masked no req", inject_req, 0);
        inject_ack = 1'b1;
        @(negedge clk);
        inject_ack = 1'b0;
        chk("R8 ack ignored while masked", pend_count, 2);
        put_entry(32'h0002_0042);
        bus_tick = 1'b1; inject_ack = 1'b1;
        @(negedge clk);
        bus_tick = 1'b0; inject_ack = 1'b0;
        chk("R8 expiry plus consume", pend_count, 2);

        // R7 saturation
        bus_tick = 1'b1;
        repeat (20) @(negedge clk);
        bus_tick = 1'b0;
        @(negedge clk);
        chk("R7 saturated", pend_count, 15);
        put_init(1);
        chk("R3 clear from full", pend_count, 0);

        // R9 software disable
        bus_tick = 1'b1;
        repeat (4) @(negedge clk);
        bus_tick = 1'b0;
        @(negedge clk);
        chk("R9 pending before", pend_count, 4);
        put_ctl(1'b0);
        chk("R9 pending cleared", pend_count, 0);
        chk("R9 entry masked", entry_value, 32'h0003_0042);

        // R10 field filtering
        put_entry(32'hFFFF_FFFF);
        chk("R10 disabled all ones", entry_value, 32'h0003_10FF);
        put_entry(32'h0000_00AB);
        chk("R10 disabled forced mask", entry_value, 32'h0001_00AB);
        put_ctl(1'b1);
        put_entry(32'h0000_00AB);
        chk("R10 enabled unmasked", entry_value, 32'h0000_00AB);
        put_entry(32'hFFFF_FFFF);
        chk("R10 enabled all ones", entry_value, 32'h0003_10FF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule